// File: doc/BRIEF.md
# SD Command Response Start Detector

After a command frame has been sent to an SD card, the host has to find the first bit of the card's reply on the CMD line. This block runs that search. A start strobe launches it. The block first waits through one idle generator period. It then produces SD clock pulses one at a time, and each pulse lasts a full divider period before the next one may begin. During each pulse it looks at CMD once, a fixed number of system cycles after the pulse begins and before the clock rises. A low level at that moment is taken as the response start bit, and the search stops at once with the clock held low.

The search is bounded by a number of SD clock pulses, not by elapsed time. If CMD stays high for the whole allowance (64 pulses by default), the block reports a timeout. Either outcome raises a one-cycle done strobe. The outcome flags and the pulse number at which the start bit was seen stay valid until the next search begins. The divider ratio, the sample offset and the pulse limit are parameters.

Top module: `sdrsp_start_detect`

## Requirements
- R1: While reset is held and afterwards until a start is taken, sdClk, busy, done, found, timedOut and pulseNum are all 0.
- R2: A start seen high while idle is accepted at that clock edge. busy is 1 from the next cycle until the search ends. The first SD clock period (CLK_DIV cycles) stays low, so the first rising edge appears in the second period.
- R3: Each generated pulse lasts exactly CLK_DIV system cycles. sdClk is low for the first CLK_DIV/2 cycles and high for the rest, and a new pulse begins only after the previous one has fully ended.
- R4: CMD is sampled once per pulse, SAMPLE_AT cycles after the pulse begins (SAMPLE_AT < CLK_DIV/2, so before sdClk rises). A 0 there ends the search on that edge: found=1, busy=0, and sdClk stays low. The found pulse therefore never gets its rising edge.
- R5: A CMD value of 0 at any other cycle of a pulse, or during the lead-in period, has no effect.
- R6: If no start bit has been seen by the end of pulse MAX_PULSES (default 64), the search ends with timedOut=1, after exactly MAX_PULSES rising edges of sdClk.
- R7: done is a single-cycle strobe raised on the edge where the search ends. found and timedOut never both read 1. A start raised while busy is ignored.
- R8: pulseNum holds the 1-based number of the pulse in which the start bit was sampled (1 through MAX_PULSES), or MAX_PULSES after a timeout. The results are cleared when the next search is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a search when idle |
| cmdIn | input | 1 | CMD line from the card (idles high) |
| sdClk | output | 1 | Generated SD clock |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| found | output | 1 | Start bit was seen |
| timedOut | output | 1 | Pulse limit used up |
| pulseNum | output | $clog2(MAX_PULSES+1) | Pulse at which the search ended |

## Verification
Take a start accepted at edge e0, with D = CLK_DIV. Pulse k's low phase begins at edge e0+k·D, and its sample decision lands at edge e0+k·D+SAMPLE_AT+1. found and pulseNum are due right after that edge. A timeout is due at edge e0+(MAX_PULSES+1)·D. The bench model tracks the cycle count since the accepted start. It compares every output at each falling edge, which is half a period after the edge that updates it. The card stimulus is driven from the rising edges of sdClk that the bench observes, and the bench checks those against the expected rise counts. It injects a start bit at pulse 1, at pulse 5 and at pulse 64. It also runs with no start bit at all, and with a CMD low level that only ever shows up outside the sample point.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_PULSE = 2'd2
  } srch_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic arm;          // clear counters and results for a new search
    logic runPhase;     // advance the in-period phase counter
    logic nextPulse;    // step the pulse counter
    logic markFound;    // record a start bit
    logic markTimeout;  // record an exhausted search
    logic clkEn;        // allow the clock high phase
  } srch_ctrl_t;

endpackage

// File: rtl/sdrsp_ctrl.sv
module sdrsp_ctrl
  import sdrsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cmdIn,
  input  logic       phaseLast,
  input  logic       phaseSample,
  input  logic       pulseLast,
  output srch_ctrl_t ctrl,
  output logic       busy,
  output logic       done
);

  srch_state_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.arm = 1'b1;
          stateNxt = ST_LEAD;
        end
      end
      ST_LEAD: begin
        ctrl.runPhase = 1'b1;
        if (phaseLast) begin
          ctrl.nextPulse = 1'b1;
          stateNxt       = ST_PULSE;
        end
      end
      ST_PULSE: begin
        ctrl.runPhase = 1'b1;
        ctrl.clkEn    = 1'b1;
        if (phaseSample && !cmdIn) begin
          ctrl.markFound = 1'b1;
          stateNxt       = ST_IDLE;
        end else if (phaseLast) begin
          if (pulseLast) begin
            ctrl.markTimeout = 1'b1;
            stateNxt         = ST_IDLE;
          end else begin
            ctrl.nextPulse = 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= ctrl.markFound | ctrl.markTimeout;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sdrsp_dp.sv
module sdrsp_dp
  import sdrsp_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int SAMPLE_AT  = 1,
  parameter int MAX_PULSES = 64,
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  srch_ctrl_t    ctrl,
  output logic          phaseLast,
  output logic          phaseSample,
  output logic          pulseLast,
  output logic          sdClk,
  output logic          found,
  output logic          timedOut,
  output logic [CW-1:0] pulseNum
);

  localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
  localparam logic [PW-1:0] PH_SMP  = PW'(SAMPLE_AT);
  localparam logic [PW-1:0] PH_HIGH = PW'(CLK_DIV / 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PULSES);

  logic [PW-1:0] phase;
  logic [CW-1:0] pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.arm) begin
      phase <= '0;
    end else if (ctrl.runPhase) begin
      phase <= phaseLast ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.arm) begin
      pulseCnt <= '0;
    end else if (ctrl.nextPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.arm) begin
      found    <= 1'b0;
      timedOut <= 1'b0;
      pulseNum <= '0;
    end else if (ctrl.markFound) begin
      found    <= 1'b1;
      pulseNum <= pulseCnt;
    end else if (ctrl.markTimeout) begin
      timedOut <= 1'b1;
      pulseNum <= pulseCnt;
    end
  end

  assign phaseLast   = (phase == PH_LAST);
  assign phaseSample = (phase == PH_SMP);
  assign pulseLast   = (pulseCnt == CNT_MAX);
  assign sdClk       = ctrl.clkEn && (phase >= PH_HIGH);

endmodule

// File: rtl/sdrsp_start_detect.sv
module sdrsp_start_detect
  import sdrsp_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int SAMPLE_AT  = 1,
  parameter int MAX_PULSES = 64,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cmdIn,
  output logic          sdClk,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic          timedOut,
  output logic [CW-1:0] pulseNum
);

  srch_ctrl_t ctrl;
  logic phaseLast, phaseSample, pulseLast;

  sdrsp_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cmdIn       (cmdIn),
    .phaseLast   (phaseLast),
    .phaseSample (phaseSample),
    .pulseLast   (pulseLast),
    .ctrl        (ctrl),
    .busy        (busy),
    .done        (done)
  );

  sdrsp_dp #(
    .CLK_DIV    (CLK_DIV),
    .SAMPLE_AT  (SAMPLE_AT),
    .MAX_PULSES (MAX_PULSES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .phaseLast   (phaseLast),
    .phaseSample (phaseSample),
    .pulseLast   (pulseLast),
    .sdClk       (sdClk),
    .found       (found),
    .timedOut    (timedOut),
    .pulseNum    (pulseNum)
  );

endmodule

// File: rtl/sdrsp_start_detect_chk.sv
module sdrsp_start_detect_chk #(
  parameter int MAX_PULSES = 64,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          cmdIn,
  input logic          sdClk,
  input logic          busy,
  input logic          done,
  input logic          found,
  input logic          timedOut,
  input logic [CW-1:0] pulseNum
);

  // R1: the clock is quiet whenever no search runs
  p_clk_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdClk);

  // R2: a search only begins from a start strobe
  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R4: found only rises after CMD was seen low
  p_found_on_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(found) |-> !$past(cmdIn));

  // R4: the search ends with the clock low
  p_clk_low_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !sdClk);

  // R6: a timeout reports the full pulse allowance
  p_timeout_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> (pulseNum == CW'(MAX_PULSES)));

  // R7: done is one cycle wide and marks the end of busy
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(found && timedOut));

  // R8: a found pulse number is in range
  p_found_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (pulseNum != '0 && pulseNum <= CW'(MAX_PULSES)));

endmodule

bind sdrsp_start_detect sdrsp_start_detect_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .cmdIn    (cmdIn),
  .sdClk    (sdClk),
  .busy     (busy),
  .done     (done),
  .found    (found),
  .timedOut (timedOut),
  .pulseNum (pulseNum)
);

// File: tb/sdrsp_start_detect_tb_top.sv
module sdrsp_start_detect_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;
  localparam int P   = 1;
  localparam int MAX = 64;
  localparam int H   = D / 2;
  localparam int CW  = $clog2(MAX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cmdIn = 1'b1;
  logic sdClk, busy, done, found, timedOut;
  logic [CW-1:0] pulseNum;

  int errors = 0;
  int checks = 0;
  bit cmpOn = 1'b0;

  // reference model state
  bit mActive, mDone, mFound, mTo;
  int mCyc, mNum;

  sdrsp_start_detect #(.CLK_DIV(D), .SAMPLE_AT(P), .MAX_PULSES(MAX)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdIn(cmdIn),
    .sdClk(sdClk), .busy(busy), .done(done), .found(found),
    .timedOut(timedOut), .pulseNum(pulseNum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: counts cycles since the accepted start
  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mDone = 0; mFound = 0; mTo = 0; mCyc = 0; mNum = 0;
    end else begin
      mDone = 0;
      if (!mActive) begin
        if (start) begin
          mActive = 1; mCyc = 0; mFound = 0; mTo = 0; mNum = 0;
        end
      end else begin
        int k, ph;
        mCyc++;
        k  = (mCyc - 1) / D;
        ph = (mCyc - 1) % D;
        if (k >= 1 && ph == P && cmdIn == 1'b0) begin
          mActive = 0; mFound = 1; mNum = k; mDone = 1;
        end else if (k == MAX && ph == D - 1) begin
          mActive = 0; mTo = 1; mNum = MAX; mDone = 1;
        end
      end
    end
  end

  function automatic int expClk();
    if (!mActive) return 0;
    return ((mCyc / D) >= 1 && (mCyc % D) >= H) ? 1 : 0;
  endfunction

  // per-cycle comparison, half a period after the updating edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R3", "sdClk", int'(sdClk), expClk());
      check("R2", "busy", int'(busy), int'(mActive));
      check("R7", "done", int'(done), int'(mDone));
      check("R4", "found", int'(found), int'(mFound));
      check("R6", "timedOut", int'(timedOut), int'(mTo));
      check("R8", "pulseNum", int'(pulseNum), mNum);
    end
  end

  // mode 0: CMD high, 1: low from pulse startAt, 2: low only while sdClk high
  task automatic runSearch(input int mode, input int startAt, input bit poke,
                           input int expFound, input int expNum, input int expRises,
                           input string req);
    int rises = 0;
    bit prevClk = 1'b0;
    bit seen = 1'b0;
    @(negedge clk);
    start = 1'b1;
    cmdIn = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      if (sdClk && !prevClk) rises++;
      prevClk = sdClk;
      if (done) begin
        seen = 1'b1;
        break;
      end
      if (mode == 1)      cmdIn = (rises >= startAt - 1) ? 1'b0 : 1'b1;
      else if (mode == 2) cmdIn = ~sdClk;
      else                cmdIn = 1'b1;
      start = (poke && n == 10) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    cmdIn = 1'b1;
    check(req, "done seen", int'(seen), 1);
    check(req, "found flag", int'(found), expFound);
    check(req, "timeout flag", int'(timedOut), 1 - expFound);
    check(req, "pulse number", int'(pulseNum), expNum);
    check(req, "sdClk rising edges", rises, expRises);
    @(negedge clk);
    check("R7", "done dropped", int'(done), 0);
    check("R8", "result held", int'(pulseNum), expNum);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "sdClk in reset", int'(sdClk), 0);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "found in reset", int'(found), 0);
    check("R1", "timedOut in reset", int'(timedOut), 0);
    check("R1", "pulseNum in reset", int'(pulseNum), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "idle after reset", int'(busy), 0);

    // R4 R8: start bit at the first pulse
    runSearch(1, 1, 1'b0, 1, 1, 0, "R4");
    // R4 R7: start bit at pulse 5, start poked while busy
    runSearch(1, 5, 1'b1, 1, 5, 4, "R7");
    // R8: start bit at the last allowed pulse
    runSearch(1, MAX, 1'b0, 1, MAX, MAX - 1, "R8");
    // R6: never answers
    runSearch(0, 0, 1'b0, 0, MAX, MAX, "R6");
    // R5: low only away from the sample point
    runSearch(2, 0, 1'b0, 0, MAX, MAX, "R5");
    // R2 R3: back-to-back search after a timeout
    runSearch(1, 2, 1'b0, 1, 2, 1, "R2");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule